// File: doc/BRIEF.md
# Scroll Map Row Remapper

This block holds a small table that tells the display fetch logic which stored memory row to fetch for each row on the screen. Each entry is an 8-bit row pointer plus a show flag. Scrolling, reordering or hiding rows is done by rewriting a few entries; the page in display memory is never moved. Entries 0 to 24 cover the main page rows and entry 25 covers a local status row.

The host loads entries through a simple write port and reads them back through a registered read port. The display timing side pulses `row_start` at each row boundary together with the index of the row that is about to be scanned. The block then presents that row's memory pointer together with either a fetch request or a blank-row indication. The row format input limits how many main rows are eligible: 20, 21 or 25. These outputs are latched at the boundary and held for the whole row, so a host write never changes a row that is already being scanned.

Top module: `scroll_row_map`

## Requirements
- R1: After reset every entry's show flag reads back as 0 and its pointer as 0. `row_blank` is 1, `row_fetch` is 0 and `row_ptr` is 0.
- R2: A write with `wr_en`=1 and `wr_idx` in 0..25 stores `wr_ptr` and `wr_show` in that entry. The stored values appear on `rd_ptr`/`rd_show` one clock after a clock edge at which `rd_idx` selects the entry.
- R3: A write with `wr_idx` in 26..31 changes no entry. A read with `rd_idx` in 26..31 returns pointer 0 and show 0.
- R4: At a clock edge with `row_start`=1, the entry selected by `scan_row` is sampled. If that row is eligible and its show flag is 1, then from the next cycle `row_fetch`=1, `row_blank`=0 and `row_ptr` equals the entry's pointer.
- R5: A row whose entry has show flag 0 gives `row_blank`=1, `row_fetch`=0 and `row_ptr`=0.
- R6: `row_ptr`, `row_fetch` and `row_blank` change only after a clock edge with `row_start`=1. Host writes between boundaries do not alter them.
- R7: A write at the same clock edge as `row_start` is not seen by the row starting at that edge. It is seen from the next boundary on.
- R8: `row_fmt` encodes 0 = 20 main rows, 1 = 21 main rows, 2 or 3 = 25 main rows. A `scan_row` at or above the main-row count, other than 25, is blanked whatever its entry holds.
- R9: Row index 25 is the status row. It is eligible in every format and follows its entry as in R4/R5.
- R10: `row_fetch` and `row_blank` are always complements of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | 5 | Entry index for the write |
| wr_show | input | 1 | Show flag to store |
| wr_ptr | input | 8 | Memory row pointer to store |
| rd_idx | input | 5 | Entry index for host read-back |
| rd_show | output | 1 | Read-back show flag, one cycle latency |
| rd_ptr | output | 8 | Read-back pointer, one cycle latency |
| row_start | input | 1 | Row boundary pulse from display timing |
| scan_row | input | 5 | Index of the row beginning at this boundary |
| row_fmt | input | 2 | Main-row count select (see R8) |
| row_ptr | output | 8 | Memory row to fetch for the current row |
| row_fetch | output | 1 | Current row is fetched |
| row_blank | output | 1 | Current row is shown blank |

## Verification
The bench goes after the boundary cases. One is a write landing on the very edge of `row_start`: a design that reads the table after the write would show the new pointer one row too early. Another is writes between boundaries: a design that looks up combinationally would change the pointer mid-row. The bench also checks the last eligible row of each format and the first one past it, so an off-by-one in the row limit shows up as a wrongly fetched or wrongly blanked row. It also checks that the status row stays visible under the 20-row format. Out-of-range write indices follow the real entries; a design that aliases index bits would corrupt a low entry, and the read-back shows it.

// File: rtl/smap_pkg.sv
package smap_pkg;

  typedef enum logic [1:0] {
    FMT_SHORT = 2'd0,
    FMT_MID   = 2'd1,
    FMT_LONG  = 2'd2,
    FMT_LONG2 = 2'd3
  } row_fmt_e;

endpackage

// File: rtl/smap_table.sv
module smap_table #(
  parameter int unsigned N    = 26,
  parameter int unsigned IW   = 5,
  parameter int unsigned PW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_show,
  input  logic [PW-1:0] wr_ptr,
  input  logic [IW-1:0] a_idx,
  output logic          a_show,
  output logic [PW-1:0] a_ptr,
  input  logic [IW-1:0] b_idx,
  output logic          b_show,
  output logic [PW-1:0] b_ptr
);

  localparam logic [IW-1:0] NUM_I = IW'(N);

  logic [N-1:0]         show_q, show_d;
  logic [N-1:0][PW-1:0] ptr_q, ptr_d;

  // per-entry next-state
  for (genvar e = 0; e < N; e++) begin : g_ent
    logic hit;
    assign hit      = wr_en && (wr_idx == IW'(e));
    assign show_d[e] = hit ? wr_show : show_q[e];
    assign ptr_d[e]  = hit ? wr_ptr  : ptr_q[e];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      show_q <= '0;
      ptr_q  <= '0;
    end else if (wr_en) begin
      show_q <= show_d;
      ptr_q  <= ptr_d;
    end
  end

  always_comb begin
    a_show = 1'b0;
    a_ptr  = '0;
    if (a_idx < NUM_I) begin
      a_show = show_q[a_idx];
      a_ptr  = ptr_q[a_idx];
    end
  end

  always_comb begin
    b_show = 1'b0;
    b_ptr  = '0;
    if (b_idx < NUM_I) begin
      b_show = show_q[b_idx];
      b_ptr  = ptr_q[b_idx];
    end
  end

  // R3: an index past the table leaves every entry untouched
  p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= NUM_I) |=> ($stable(show_q) && $stable(ptr_q)));

  // R2: a valid write lands in the addressed entry
  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < NUM_I) |=>
      (show_q[$past(wr_idx)] == $past(wr_show) && ptr_q[$past(wr_idx)] == $past(wr_ptr)));

endmodule

// File: rtl/smap_host_rd.sv
module smap_host_rd #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ent_show,
  input  logic [PW-1:0] ent_ptr,
  output logic          rd_show,
  output logic [PW-1:0] rd_ptr
);

  logic          show_d;
  logic [PW-1:0] ptr_d;

  always_comb begin
    show_d = ent_show;
    ptr_d  = ent_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_show <= 1'b0;
      rd_ptr  <= '0;
    end else begin
      rd_show <= show_d;
      rd_ptr  <= ptr_d;
    end
  end

endmodule

// File: rtl/smap_row_latch.sv
module smap_row_latch #(
  parameter int unsigned IW         = 5,
  parameter int unsigned PW         = 8,
  parameter int unsigned ROWS_SHORT = 20,
  parameter int unsigned ROWS_MID   = 21,
  parameter int unsigned ROWS_LONG  = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_start,
  input  logic [IW-1:0] scan_row,
  input  logic [1:0]    row_fmt,
  input  logic          ent_show,
  input  logic [PW-1:0] ent_ptr,
  output logic [PW-1:0] row_ptr,
  output logic          row_fetch,
  output logic          row_blank
);

  import smap_pkg::*;

  localparam logic [IW-1:0] STATUS_I = IW'(ROWS_LONG);
  localparam logic [IW-1:0] SHORT_I  = IW'(ROWS_SHORT);
  localparam logic [IW-1:0] MID_I    = IW'(ROWS_MID);
  localparam logic [IW-1:0] LONG_I   = IW'(ROWS_LONG);

  logic [IW-1:0] limit;
  logic          eligible;
  logic          fetch_d;
  logic [PW-1:0] ptr_d;

  always_comb begin
    case (row_fmt_e'(row_fmt))
      FMT_SHORT: limit = SHORT_I;
      FMT_MID:   limit = MID_I;
      default:   limit = LONG_I;
    endcase
    eligible = (scan_row < limit) || (scan_row == STATUS_I);
    fetch_d  = eligible && ent_show;
    ptr_d    = fetch_d ? ent_ptr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_ptr   <= '0;
      row_fetch <= 1'b0;
      row_blank <= 1'b1;
    end else if (row_start) begin
      row_ptr   <= ptr_d;
      row_fetch <= fetch_d;
      row_blank <= !fetch_d;
    end
  end

  // R6: outputs hold for the whole row
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !row_start |=> ($stable(row_ptr) && $stable(row_fetch) && $stable(row_blank)));

  // R10: exactly one of fetch or blank
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    row_fetch != row_blank);

  // R5: a blank row carries no pointer
  p_blank_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    row_blank |-> (row_ptr == '0));

  // R8: past the short-format limit a main row is blanked
  p_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_start && row_fmt == 2'd0 && scan_row >= SHORT_I && scan_row != STATUS_I) |=> row_blank);

  // R9: the status row follows its own entry in every format
  p_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (row_start && scan_row == STATUS_I && ent_show) |=> (row_fetch && row_ptr == $past(ent_ptr)));

endmodule

// File: rtl/scroll_row_map.sv
module scroll_row_map #(
  parameter int unsigned PTR_W      = 8,
  parameter int unsigned ROWS_SHORT = 20,
  parameter int unsigned ROWS_MID   = 21,
  parameter int unsigned ROWS_LONG  = 25,
  localparam int unsigned NUM_ENT   = ROWS_LONG + 1,
  localparam int unsigned IDX_W     = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_show,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_show,
  output logic [PTR_W-1:0] rd_ptr,
  input  logic             row_start,
  input  logic [IDX_W-1:0] scan_row,
  input  logic [1:0]       row_fmt,
  output logic [PTR_W-1:0] row_ptr,
  output logic             row_fetch,
  output logic             row_blank
);

  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic             a_show, b_show;
  logic [PTR_W-1:0] a_ptr, b_ptr;

  smap_table #(.N(NUM_ENT), .IW(IDX_W), .PW(PTR_W)) table_i (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_show (wr_show),
    .wr_ptr  (wr_ptr),
    .a_idx   (rd_idx),
    .a_show  (a_show),
    .a_ptr   (a_ptr),
    .b_idx   (scan_row),
    .b_show  (b_show),
    .b_ptr   (b_ptr)
  );

  smap_host_rd #(.PW(PTR_W)) host_rd_i (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .ent_show (a_show),
    .ent_ptr  (a_ptr),
    .rd_show  (rd_show),
    .rd_ptr   (rd_ptr)
  );

  smap_row_latch #(
    .IW(IDX_W), .PW(PTR_W),
    .ROWS_SHORT(ROWS_SHORT), .ROWS_MID(ROWS_MID), .ROWS_LONG(ROWS_LONG)
  ) row_latch_i (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .row_start (row_start),
    .scan_row  (scan_row),
    .row_fmt   (row_fmt),
    .ent_show  (b_show),
    .ent_ptr   (b_ptr),
    .row_ptr   (row_ptr),
    .row_fetch (row_fetch),
    .row_blank (row_blank)
  );

endmodule

// File: tb/scroll_row_map_tb_top.sv
`timescale 1ns/1ps
module scroll_row_map_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_show, row_start;
  logic [4:0] wr_idx, rd_idx, scan_row;
  logic [7:0] wr_ptr;
  logic [1:0] row_fmt;
  logic       rd_show, row_fetch, row_blank;
  logic [7:0] rd_ptr, row_ptr;

  always #2.5 clk = ~clk;

  scroll_row_map dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_show(wr_show), .wr_ptr(wr_ptr),
    .rd_idx(rd_idx), .rd_show(rd_show), .rd_ptr(rd_ptr),
    .row_start(row_start), .scan_row(scan_row), .row_fmt(row_fmt),
    .row_ptr(row_ptr), .row_fetch(row_fetch), .row_blank(row_blank)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string tag    = "R1";

  // behavioural reference model
  int m_ptr [26];
  bit m_show[26];
  int e_rd_ptr, e_row_ptr;
  bit e_rd_show, e_fetch, e_blank;

  function automatic int row_limit(input int fmt);
    if (fmt == 0) return 20;
    if (fmt == 1) return 21;
    return 25;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 26; i++) begin m_ptr[i] = 0; m_show[i] = 0; end
      e_rd_ptr = 0; e_rd_show = 0; e_row_ptr = 0; e_fetch = 0; e_blank = 1;
    end else begin
      if (rd_idx < 26) begin e_rd_ptr = m_ptr[rd_idx]; e_rd_show = m_show[rd_idx]; end
      else begin e_rd_ptr = 0; e_rd_show = 0; end
      if (row_start) begin
        bit ok;
        ok = (scan_row < row_limit(row_fmt) || scan_row == 25) && scan_row < 26
             && m_show[scan_row];
        e_fetch = ok; e_blank = !ok; e_row_ptr = ok ? m_ptr[scan_row] : 0;
      end
      if (wr_en && wr_idx < 26) begin m_ptr[wr_idx] = wr_ptr; m_show[wr_idx] = wr_show; end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rd_ptr !== 8'(e_rd_ptr) || rd_show !== e_rd_show || row_ptr !== 8'(e_row_ptr) ||
          row_fetch !== e_fetch || row_blank !== e_blank) begin
        errors++;
        $display("FAIL %s rd=%0b/%0h row=%0h f=%0b b=%0b expected rd=%0b/%0h row=%0h f=%0b b=%0b",
                 tag, rd_show, rd_ptr, row_ptr, row_fetch, row_blank,
                 e_rd_show, e_rd_ptr[7:0], e_row_ptr[7:0], e_fetch, e_blank);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int idx, input bit show, input int ptr);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'(idx); wr_show = show; wr_ptr = 8'(ptr);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic row(input int idx);
    @(negedge clk);
    row_start = 1; scan_row = 5'(idx);
    @(negedge clk);
    row_start = 0;
  endtask

  task automatic rd_all();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); rd_idx = 5'(i);
    end
    idle(2);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_idx = 0; wr_show = 0; wr_ptr = 0;
    rd_idx = 0; row_start = 0; scan_row = 0; row_fmt = 2'd2;
    idle(4);
    rst_n = 1;
    idle(4);

    // R1: cleared table and blank output after reset
    tag = "R1";
    rd_all();
    row(3); row(25); idle(2);

    // R2: load every entry and read back
    tag = "R2";
    for (int i = 0; i < 26; i++) wr(i, (i != 5 && i != 13), (i * 37 + 11) & 255);
    rd_all();

    // R4: rows in reverse order under the 25-row format
    tag = "R4";
    row_fmt = 2'd2;
    for (int i = 24; i >= 0; i -= 3) begin row(i); idle(2); end

    // R5: hidden rows
    tag = "R5";
    row(5); idle(1); row(13); idle(1);
    wr(7, 0, 8'h44); row(7); idle(1);

    // R6: writes between boundaries leave the current row alone
    tag = "R6";
    row(2); wr(2, 1, 8'hA5); wr(2, 0, 8'h5A); idle(3);
    row(2); idle(2);

    // R7: write on the boundary edge
    tag = "R7";
    wr(9, 1, 8'h10);
    @(negedge clk);
    row_start = 1; scan_row = 5'd9; wr_en = 1; wr_idx = 5'd9; wr_show = 1; wr_ptr = 8'hC3;
    @(negedge clk);
    row_start = 0; wr_en = 0;
    idle(2); row(9); idle(2);

    // R8: main-row limits per format
    tag = "R8";
    wr(19, 1, 8'h91); wr(20, 1, 8'h92); wr(21, 1, 8'h93); wr(24, 1, 8'h94);
    row_fmt = 2'd0; row(19); row(20); row(24);
    row_fmt = 2'd1; row(20); row(21);
    row_fmt = 2'd3; row(24); row(21); idle(2);

    // R9: status row in every format
    tag = "R9";
    wr(25, 1, 8'hEE);
    for (int f = 0; f < 4; f++) begin row_fmt = 2'(f); row(25); idle(1); end
    wr(25, 0, 8'hEF); row(25); idle(1);

    // R3: out-of-range writes and reads
    tag = "R3";
    for (int i = 26; i < 32; i++) wr(i, 1, 8'hFF);
    rd_all();
    row(30); idle(2);

    // R10: complement across a mixed sequence
    tag = "R10";
    row_fmt = 2'd2;
    row(0); row(5); row(1); row(25); row(13); idle(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired in %s", tag);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule